// File: doc/BRIEF.md
# Posted-Write Latch for a Slow Peripheral Bus

This block sits between a CPU memory port and a slow external peripheral bus, and it tracks at most one posted write. The bus can take a CPU write only while it is idle. When it takes one, the block justifies the write data into a 32-bit holding latch and marks the bus busy for a fixed number of cycles (`DELAY`). The busy flag clears by itself once that time has run out.

A CPU read that arrives while a write is still pending does not reach the bus. It ends the pending write at once and reports how many busy cycles were still left, so the CPU can stall for that long. It returns a value built from the latch, justified for the read size. Two kinds of traffic skip the busy check. The first is a byte write to one debug address. The second is any access flagged as DMA, which never touches the latch or the timer.

The block takes one request per cycle and does not hold it back. Each result appears as a registered one-cycle pulse on the cycle after the request.

Top module: `pwl_wlatch`

## Requirements
- R1: While reset is asserted, and for two cycles after it is released, `busy`, `acc`, `stall_vld` and `rd_vld` are low. Asserting reset while a write is pending drops `busy` at once.
- R2: A CPU write (`req_dma`=0) that arrives while `busy` is low is accepted. On the next cycle `acc` is 1 and `busy` is 1.
- R3: Any CPU write that arrives while `busy` is high, other than the debug byte write of R9, is rejected. On the next cycle `acc` is 0, and neither the latch nor the remaining busy time changes.
- R4: A byte write (`req_size`=0) latches `req_wdata[7:0]`. It goes to latch bits 31:24 when `req_addr[0]`=0 and to bits 23:16 when `req_addr[0]`=1. All other latch bits become zero.
- R5: A halfword write (`req_size`=1) latches `req_wdata[15:0]` in bits 31:16 with zeros below. A word write (`req_size`=2) latches `req_wdata[31:0]`. A doubleword write (`req_size`=3) latches only `req_wdata[63:32]`.
- R6: A CPU read that arrives while `busy` is high gives `acc`=0, `stall_vld`=1 and `busy`=0 on the next cycle. `stall_cnt` then holds the number of busy cycles that were still left: `DELAY` when the read comes on the cycle right after acceptance, and one less for each cycle waited beyond that.
- R7: That same read gives `rd_vld`=1 with `rd_data` taken from the latch. For a byte read (size 0) it is latch[31:24] in bits 7:0. For a halfword read (size 1) it is latch[31:16] in bits 15:0. For a word read (size 2) it is the latch in bits 31:0. For a doubleword read (size 3) it is the latch in bits 63:32 with bits 31:0 zero.
- R8: If nothing cancels it, `busy` stays high for exactly `DELAY` consecutive cycles after a write is accepted and then clears by itself.
- R9: A byte write to address `DBG_ADDR` is forwarded (`acc`=1) even while `busy` is high. In that case it changes neither the latch nor the busy time.
- R10: A DMA access (`req_dma`=1), read or write, is always forwarded (`acc`=1). It never raises `stall_vld` or `rd_vld`, and it leaves `busy`, the latch and the busy time unchanged.
- R11: A CPU read that arrives while `busy` is low is forwarded (`acc`=1) with `stall_vld`=0 and `rd_vld`=0.
- R12: `acc`, `stall_vld` and `rd_vld` are single-cycle pulses that answer one request. On a cycle after no request they are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | Request comes from DMA and bypasses the latch |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 64 | Write data, right-justified |
| acc | output | 1 | Request was forwarded to the bus (pulse) |
| busy | output | 1 | A posted write is pending |
| rd_vld | output | 1 | `rd_data` holds latch data for a read that hit a pending write |
| rd_data | output | 64 | Justified latch data |
| stall_vld | output | 1 | Stall strobe, valid for one cycle |
| stall_cnt | output | CNT_W | Remaining busy cycles the CPU must stall |

## Verification
The bench builds the block with `DELAY`=6 and `DBG_ADDR`=0x40. With a delay this short, both the natural expiry of a posted write and every stall value, from 6 down to 1, can be reached in a few cycles each. The low debug address lets the bypass case be driven next to ordinary traffic whose addresses differ from it only in low bits. The size table then walks every write justification against every read justification.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int unsigned LATCH_W = 32;
  localparam int unsigned BUS_W   = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWRD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/pwl_rst_sync.sv
module pwl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pwl_pack.sv
// Places write data into the 32-bit latch according to access size.
module pwl_pack
  import pwl_pkg::*;
(
  input  acc_size_e          size,
  input  logic               addr_lsb,
  input  logic [BUS_W-1:0]   wdata,
  output logic [LATCH_W-1:0] word
);
  always_comb begin
    word = '0;
    unique case (size)
      SZ_BYTE: begin
        if (addr_lsb) word[23:16] = wdata[7:0];
        else          word[31:24] = wdata[7:0];
      end
      SZ_HALF: word[31:16] = wdata[15:0];
      SZ_WORD: word        = wdata[31:0];
      SZ_DWRD: word        = wdata[63:32];
      default: word        = '0;
    endcase
  end
endmodule

// File: rtl/pwl_unpack.sv
// Builds read data for a read that hits a pending write.
module pwl_unpack
  import pwl_pkg::*;
(
  input  acc_size_e          size,
  input  logic [LATCH_W-1:0] word,
  output logic [BUS_W-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    unique case (size)
      SZ_BYTE: rdata[7:0]   = word[31:24];
      SZ_HALF: rdata[15:0]  = word[31:16];
      SZ_WORD: rdata[31:0]  = word;
      SZ_DWRD: rdata[63:32] = word;
      default: rdata        = '0;
    endcase
  end
endmodule

// File: rtl/pwl_timer.sv
// Countdown of the posted-write completion time; busy while nonzero.
module pwl_timer #(
  parameter int unsigned DELAY = 100,
  parameter int unsigned CNT_W = $clog2(DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  output logic             busy,
  output logic [CNT_W-1:0] remain
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign remain = cnt_q;

  always_comb begin
    cnt_en = start | cancel | busy;
    cnt_d  = cnt_q;
    if (start)       cnt_d = LOAD;
    else if (cancel) cnt_d = '0;
    else if (busy)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwl_wlatch.sv
module pwl_wlatch
  import pwl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DELAY    = 100,
  parameter logic [ADDR_W-1:0] DBG_ADDR = ADDR_W'(32'h0500_0020),
  parameter int unsigned CNT_W    = $clog2(DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dma,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              acc,
  output logic              busy,
  output logic              rd_vld,
  output logic [63:0]       rd_data,
  output logic              stall_vld,
  output logic [CNT_W-1:0]  stall_cnt
);
  logic rst_n_s;

  pwl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  acc_size_e size_e;
  assign size_e = acc_size_e'(req_size);

  // request classification
  logic cpu_req, dma_req;
  logic wr_take, wr_dbg, rd_hit, rd_pass;

  logic             tmr_busy;
  logic [CNT_W-1:0] tmr_remain;

  always_comb begin
    dma_req = req_valid & req_dma;
    cpu_req = req_valid & ~req_dma;
    wr_take = cpu_req & req_write & ~tmr_busy;
    wr_dbg  = cpu_req & req_write & tmr_busy
              & (size_e == SZ_BYTE) & (req_addr == DBG_ADDR);
    rd_hit  = cpu_req & ~req_write & tmr_busy;
    rd_pass = cpu_req & ~req_write & ~tmr_busy;
  end

  pwl_timer #(.DELAY(DELAY), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (wr_take),
    .cancel (rd_hit),
    .busy   (tmr_busy),
    .remain (tmr_remain)
  );

  // latch storage
  logic [LATCH_W-1:0] packed_w;
  logic [LATCH_W-1:0] latch_q, latch_d;
  logic               latch_en;

  pwl_pack u_pack (
    .size     (size_e),
    .addr_lsb (req_addr[0]),
    .wdata    (req_wdata),
    .word     (packed_w)
  );

  always_comb begin
    latch_en = wr_take;
    latch_d  = packed_w;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  // response
  logic [BUS_W-1:0] unpacked_r;

  pwl_unpack u_unpack (
    .size  (size_e),
    .word  (latch_q),
    .rdata (unpacked_r)
  );

  logic             acc_d, rd_vld_d, stall_vld_d;
  logic [63:0]      rd_data_d;
  logic [CNT_W-1:0] stall_cnt_d;

  always_comb begin
    acc_d       = dma_req | wr_take | wr_dbg | rd_pass;
    rd_vld_d    = rd_hit;
    rd_data_d   = rd_hit ? unpacked_r : '0;
    stall_vld_d = rd_hit;
    stall_cnt_d = rd_hit ? tmr_remain : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc       <= 1'b0;
      rd_vld    <= 1'b0;
      rd_data   <= '0;
      stall_vld <= 1'b0;
      stall_cnt <= '0;
    end else begin
      acc       <= acc_d;
      rd_vld    <= rd_vld_d;
      rd_data   <= rd_data_d;
      stall_vld <= stall_vld_d;
      stall_cnt <= stall_cnt_d;
    end
  end

  assign busy = tmr_busy;
endmodule

// File: rtl/pwl_chk.sv
module pwl_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DELAY    = 100,
  parameter logic [ADDR_W-1:0] DBG_ADDR = '0,
  parameter int unsigned CNT_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_dma,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              acc,
  input logic              busy,
  input logic              rd_vld,
  input logic              stall_vld,
  input logic [CNT_W-1:0]  stall_cnt
);
  logic cpu_wr, cpu_rd, dbg_wr;
  assign cpu_wr = req_valid & ~req_dma & req_write;
  assign cpu_rd = req_valid & ~req_dma & ~req_write;
  assign dbg_wr = cpu_wr & (req_size == 2'd0) & (req_addr == DBG_ADDR);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && !busy |=> acc && busy);

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && busy && !dbg_wr |=> !acc);

  p_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && busy |=> !busy && stall_vld && rd_vld && !acc);

  p_stall_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_vld |-> (stall_cnt != '0) && (stall_cnt <= CNT_W'(DELAY)));

  p_debug_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr && busy |=> acc && !stall_vld);

  p_dma_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_dma |=> acc && !stall_vld && !rd_vld);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !acc && !stall_vld && !rd_vld);
endmodule

bind pwl_wlatch pwl_chk #(
  .ADDR_W(ADDR_W), .DELAY(DELAY), .DBG_ADDR(DBG_ADDR), .CNT_W(CNT_W)
) u_pwl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_dma   (req_dma),
  .req_size  (req_size),
  .req_addr  (req_addr),
  .acc       (acc),
  .busy      (busy),
  .rd_vld    (rd_vld),
  .stall_vld (stall_vld),
  .stall_cnt (stall_cnt)
);

// File: tb/test_pwl_wlatch.sv
`timescale 1ns/1ps
module test_pwl_wlatch;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DELAY  = 6;
  localparam logic [31:0] DBG    = 32'h0000_0040;
  localparam int unsigned CNT_W  = $clog2(DELAY + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, req_write, req_dma;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [63:0]       req_wdata;
  logic              acc, busy, rd_vld, stall_vld;
  logic [63:0]       rd_data;
  logic [CNT_W-1:0]  stall_cnt;

  always #10 clk = ~clk;

  pwl_wlatch #(.ADDR_W(ADDR_W), .DELAY(DELAY), .DBG_ADDR(DBG)) i_pwl_wlatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dma(req_dma), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .acc(acc), .busy(busy), .rd_vld(rd_vld),
    .rd_data(rd_data), .stall_vld(stall_vld), .stall_cnt(stall_cnt)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic req(input logic wr, input logic dma, input logic [1:0] sz,
                     input logic [31:0] addr, input logic [63:0] wd);
    req_valid = 1'b1; req_write = wr; req_dma = dma;
    req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {wsize, addr0, wdata, rsize, expected rd_data}
  typedef struct packed {
    logic [1:0]  wsz;
    logic        a0;
    logic [63:0] wd;
    logic [1:0]  rsz;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB, 2'd2, 64'h0000_0000_AB00_0000},
    '{2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FF5C, 2'd2, 64'h0000_0000_005C_0000},
    '{2'd0, 1'b0, 64'h0000_0000_0000_00AB, 2'd0, 64'h0000_0000_0000_00AB},
    '{2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_1234, 2'd1, 64'h0000_0000_0000_1234},
    '{2'd2, 1'b0, 64'h7777_7777_DEAD_BEEF, 2'd3, 64'hDEAD_BEEF_0000_0000},
    '{2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 2'd2, 64'h0000_0000_0123_4567},
    '{2'd2, 1'b0, 64'h0000_0000_CAFE_F00D, 2'd0, 64'h0000_0000_0000_00CA},
    '{2'd1, 1'b1, 64'h0000_0000_0000_BEEF, 2'd2, 64'h0000_0000_BEEF_0000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_dma = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0;
    idle(3);
    chk("R1 busy in reset", {63'b0, busy}, 64'd0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 busy after reset", {63'b0, busy}, 64'd0);
    chk("R1 strobes after reset", {61'b0, acc, stall_vld, rd_vld}, 64'd0);

    // table: write then immediate read
    foreach (VEC[k]) begin
      req(1'b1, 1'b0, VEC[k].wsz, {31'h80, VEC[k].a0}, VEC[k].wd);
      chk("R2 accept", {62'b0, acc, busy}, 64'd3);
      req(1'b0, 1'b0, VEC[k].rsz, 32'h100, 64'h0);
      chk("R4 R5 R7 latch data", rd_data, VEC[k].exp);
      chk("R6 stall count immediate", {{(64-CNT_W){1'b0}}, stall_cnt}, 64'(DELAY));
      chk("R6 cancel flags", {60'b0, acc, busy, stall_vld, rd_vld}, 64'b0011);
    end

    // R12: pulses drop on an idle cycle
    idle(1);
    chk("R12 pulses cleared", {61'b0, acc, stall_vld, rd_vld}, 64'd0);

    // R11: read when idle is forwarded
    req(1'b0, 1'b0, 2'd2, 32'h100, 64'h0);
    chk("R11 idle read", {61'b0, acc, stall_vld, rd_vld}, 64'b100);

    // R8: natural completion after DELAY cycles
    req(1'b1, 1'b0, 2'd2, 32'h200, 64'h5555_5555);
    idle(DELAY - 1);
    chk("R8 still busy at last cycle", {63'b0, busy}, 64'd1);
    idle(1);
    chk("R8 busy self-clears", {63'b0, busy}, 64'd0);

    // R6: stall shrinks with elapsed time
    req(1'b1, 1'b0, 2'd2, 32'h200, 64'h6666_6666);
    idle(3);
    req(1'b0, 1'b0, 2'd2, 32'h200, 64'h0);
    chk("R6 stall after wait", {{(64-CNT_W){1'b0}}, stall_cnt}, 64'(DELAY - 3));

    // R3: write while busy is rejected, latch unchanged
    req(1'b1, 1'b0, 2'd2, 32'h200, 64'h1111_1111);
    req(1'b1, 1'b0, 2'd2, 32'h204, 64'h2222_2222);
    chk("R3 reject acc", {63'b0, acc}, 64'd0);
    req(1'b1, 1'b0, 2'd2, DBG, 64'h9999_9999);
    chk("R3 word to debug addr rejected", {63'b0, acc}, 64'd0);
    req(1'b0, 1'b0, 2'd2, 32'h200, 64'h0);
    chk("R3 latch kept", rd_data, 64'h1111_1111);
    chk("R3 timer kept", {{(64-CNT_W){1'b0}}, stall_cnt}, 64'(DELAY - 2));

    // R9: debug byte write bypasses busy
    req(1'b1, 1'b0, 2'd2, 32'h200, 64'h3333_3333);
    req(1'b1, 1'b0, 2'd0, DBG, 64'h77);
    chk("R9 debug write forwarded", {62'b0, acc, busy}, 64'd3);
    req(1'b0, 1'b0, 2'd2, 32'h200, 64'h0);
    chk("R9 latch untouched", rd_data, 64'h3333_3333);
    chk("R9 timer untouched", {{(64-CNT_W){1'b0}}, stall_cnt}, 64'(DELAY - 1));

    // R10: DMA bypass
    req(1'b1, 1'b0, 2'd2, 32'h200, 64'h4444_4444);
    req(1'b0, 1'b1, 2'd2, 32'h200, 64'h0);
    chk("R10 dma read", {60'b0, acc, busy, stall_vld, rd_vld}, 64'b1100);
    req(1'b1, 1'b1, 2'd2, 32'h200, 64'h8888_8888);
    chk("R10 dma write", {60'b0, acc, busy, stall_vld, rd_vld}, 64'b1100);
    req(1'b0, 1'b0, 2'd2, 32'h200, 64'h0);
    chk("R10 latch untouched", rd_data, 64'h4444_4444);
    chk("R10 timer untouched", {{(64-CNT_W){1'b0}}, stall_cnt}, 64'(DELAY - 2));

    // R1: reset while busy
    req(1'b1, 1'b0, 2'd2, 32'h200, 64'h1234_5678);
    chk("R1 busy before reset", {63'b0, busy}, 64'd1);
    rst_n = 1'b0;
    idle(1);
    chk("R1 reset drops busy", {63'b0, busy}, 64'd0);
    rst_n = 1'b1;
    idle(3);
    req(1'b0, 1'b0, 2'd2, 32'h200, 64'h0);
    chk("R1 no stall after reset", {62'b0, stall_vld, acc}, 64'b01);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule